// File: doc/BRIEF.md
# Link Power State Sequencer

This block moves a USB 2.0 link among three power levels: fully on, a shallow sleep and a deep suspend. Requests to sleep, to suspend and to resume come in as single-cycle pulses. Each step between levels takes a fixed number of clock cycles, and every such count is a parameter. A single down-counter times whichever step is running. The block outputs the last settled level and a busy flag that is high for the whole of a step. It also raises a clock-stop request, but only once the link has fully reached suspend.

The sleep steps are short, on the order of tens of microseconds. The suspend steps are long, on the order of milliseconds. An upstream bus reset overrides everything else: it aborts any step that is running and returns the link to the on level. The surrounding controller reads the level and busy outputs to decide when to gate its own clocks and when to serve traffic. This block does not drive line signalling and does not gate any clock itself.

Top module: `link_pwr_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `link_state` is 2'b00, `busy` is 0 and `clk_stop_req` is 0.
- R2: `link_state` uses 2'b00 for on, 2'b01 for sleep and 2'b10 for suspend, and never shows 2'b11. During a step it keeps the level being left, and it takes the new level on the same cycle that `busy` falls.
- R3: A `req_sleep` pulse in settled on starts the sleep entry. `busy` is then high for exactly `SLP_ENTRY_CYC` cycles and `link_state` becomes 2'b01. A `req_resume` pulse in settled sleep keeps `busy` high for exactly `SLP_EXIT_CYC` cycles and then returns `link_state` to 2'b00.
- R4: A `req_suspend` pulse in settled on keeps `busy` high for exactly `SUS_ENTRY_CYC` cycles and then sets `link_state` to 2'b10. A `req_resume` pulse in settled suspend keeps `busy` high for exactly `SUS_EXIT_CYC` cycles and then returns `link_state` to 2'b00.
- R5: A `bus_reset` in settled suspend puts `link_state` at 2'b00 on the next cycle, with `busy` and `clk_stop_req` both low.
- R6: `clk_stop_req` is high only while the link is settled in suspend: `link_state` is 2'b10 and `busy` is 0. It is low in on, in sleep and during every step.
- R7: Any request that arrives while `busy` is high is ignored. The step still lasts its full parameter count and ends at its original target.
- R8: In settled sleep, `req_sleep` and `req_suspend` have no effect, because sleep and suspend are never linked directly. In settled on, `req_resume` has no effect.
- R9: `bus_reset` wins over every request that arrives in the same cycle. It also aborts a step in progress, so on the next cycle `link_state` is 2'b00 and `busy` is 0.
- R10: When `req_sleep` and `req_suspend` arrive together in settled on, the suspend entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_sleep | input | 1 | Request to enter sleep |
| req_suspend | input | 1 | Request to enter suspend |
| req_resume | input | 1 | Request to return to on |
| bus_reset | input | 1 | Upstream bus reset, forces the on level |
| link_state | output | 2 | Settled level: 00 on, 01 sleep, 10 suspend |
| busy | output | 1 | High while a step is being timed |
| clk_stop_req | output | 1 | Clock stop allowed, settled suspend only |

## Verification
The bench counts the busy window of each of the four steps to the exact cycle. An off-by-one in the counter reload or in the expiry test would lengthen or shorten that window by one cycle. It sends requests in the middle of a step and illegal requests in settled sleep and on. A design that accepted them would cut a step short, restart it, or cross directly between sleep and suspend. It applies a bus reset during an entry, in suspend, and together with a request. A design that let the request win or let the counter keep running would stay busy or leave the clock-stop request high. It also raises both entry requests at once, which exposes a wrong priority between sleep and suspend.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [1:0] {
    LS_ON    = 2'b00,
    LS_SLEEP = 2'b01,
    LS_SUSP  = 2'b10
  } lstate_t;

  typedef enum logic [2:0] {
    PH_ON,
    PH_SLP_IN,
    PH_SLP,
    PH_SLP_OUT,
    PH_SUS_IN,
    PH_SUS,
    PH_SUS_OUT
  } phase_t;

  // level shown to the outside for a phase: the level being left during a step
  function automatic lstate_t phase_level(input phase_t ph);
    case (ph)
      PH_SLP, PH_SLP_OUT: return LS_SLEEP;
      PH_SUS, PH_SUS_OUT: return LS_SUSP;
      default:            return LS_ON;
    endcase
  endfunction

  function automatic logic phase_moving(input phase_t ph);
    return (ph == PH_SLP_IN) || (ph == PH_SLP_OUT) ||
           (ph == PH_SUS_IN) || (ph == PH_SUS_OUT);
  endfunction

endpackage

// File: rtl/lps_timer.sv
module lps_timer #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
#(
  parameter int SLP_ENTRY_CYC = 65,
  parameter int SLP_EXIT_CYC  = 100,
  parameter int SUS_ENTRY_CYC = 300,
  parameter int SUS_EXIT_CYC  = 200,
  parameter int CW            = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_sleep,
  input  logic          req_suspend,
  input  logic          req_resume,
  input  logic          bus_reset,
  input  logic          tmr_expired,
  output logic          tmr_clear,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output phase_t        phase_next
);

  // reload values: a step of N cycles loads N-1 and settles when zero is seen
  localparam logic [CW-1:0] LD_SLP_IN  = CW'(SLP_ENTRY_CYC - 1);
  localparam logic [CW-1:0] LD_SLP_OUT = CW'(SLP_EXIT_CYC - 1);
  localparam logic [CW-1:0] LD_SUS_IN  = CW'(SUS_ENTRY_CYC - 1);
  localparam logic [CW-1:0] LD_SUS_OUT = CW'(SUS_EXIT_CYC - 1);

  phase_t phase_q;

  always_comb begin
    phase_next = phase_q;
    tmr_clear  = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    if (bus_reset) begin
      phase_next = PH_ON;
      tmr_clear  = 1'b1;
    end else begin
      unique case (phase_q)
        PH_ON: begin
          if (req_suspend) begin
            phase_next = PH_SUS_IN;
            tmr_load   = 1'b1;
            tmr_val    = LD_SUS_IN;
          end else if (req_sleep) begin
            phase_next = PH_SLP_IN;
            tmr_load   = 1'b1;
            tmr_val    = LD_SLP_IN;
          end
        end
        PH_SLP: begin
          if (req_resume) begin
            phase_next = PH_SLP_OUT;
            tmr_load   = 1'b1;
            tmr_val    = LD_SLP_OUT;
          end
        end
        PH_SUS: begin
          if (req_resume) begin
            phase_next = PH_SUS_OUT;
            tmr_load   = 1'b1;
            tmr_val    = LD_SUS_OUT;
          end
        end
        PH_SLP_IN:  if (tmr_expired) phase_next = PH_SLP;
        PH_SUS_IN:  if (tmr_expired) phase_next = PH_SUS;
        PH_SLP_OUT: if (tmr_expired) phase_next = PH_ON;
        PH_SUS_OUT: if (tmr_expired) phase_next = PH_ON;
        default:    phase_next = PH_ON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_ON;
    else     phase_q <= phase_next;
  end

endmodule

// File: rtl/lps_status.sv
module lps_status
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     phase_next,
  output logic [1:0] link_state,
  output logic       busy,
  output logic       clk_stop_req
);

  always_ff @(posedge clk) begin
    if (rst) begin
      link_state   <= LS_ON;
      busy         <= 1'b0;
      clk_stop_req <= 1'b0;
    end else begin
      link_state   <= phase_level(phase_next);
      busy         <= phase_moving(phase_next);
      clk_stop_req <= (phase_next == PH_SUS);
    end
  end

endmodule

// File: rtl/link_pwr_seq.sv
module link_pwr_seq
  import lps_pkg::*;
#(
  parameter int SLP_ENTRY_CYC = 65,
  parameter int SLP_EXIT_CYC  = 100,
  parameter int SUS_ENTRY_CYC = 300,
  parameter int SUS_EXIT_CYC  = 200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_sleep,
  input  logic       req_suspend,
  input  logic       req_resume,
  input  logic       bus_reset,
  output logic [1:0] link_state,
  output logic       busy,
  output logic       clk_stop_req
);

  localparam int MAX_SLP = (SLP_ENTRY_CYC > SLP_EXIT_CYC) ? SLP_ENTRY_CYC : SLP_EXIT_CYC;
  localparam int MAX_SUS = (SUS_ENTRY_CYC > SUS_EXIT_CYC) ? SUS_ENTRY_CYC : SUS_EXIT_CYC;
  localparam int MAX_LAT = (MAX_SLP > MAX_SUS) ? MAX_SLP : MAX_SUS;
  localparam int CW      = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT);

  logic          tmr_clear;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expired;
  phase_t        phase_next;

  lps_fsm #(
    .SLP_ENTRY_CYC (SLP_ENTRY_CYC),
    .SLP_EXIT_CYC  (SLP_EXIT_CYC),
    .SUS_ENTRY_CYC (SUS_ENTRY_CYC),
    .SUS_EXIT_CYC  (SUS_EXIT_CYC),
    .CW            (CW)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_sleep   (req_sleep),
    .req_suspend (req_suspend),
    .req_resume  (req_resume),
    .bus_reset   (bus_reset),
    .tmr_expired (tmr_expired),
    .tmr_clear   (tmr_clear),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .phase_next  (phase_next)
  );

  lps_timer #(
    .CW (CW)
  ) i_timer (
    .clk      (clk),
    .rst      (rst),
    .clear    (tmr_clear),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  lps_status i_status (
    .clk          (clk),
    .rst          (rst),
    .phase_next   (phase_next),
    .link_state   (link_state),
    .busy         (busy),
    .clk_stop_req (clk_stop_req)
  );

endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int SLP_ENTRY_CYC = 65,
  parameter int SLP_EXIT_CYC  = 100,
  parameter int SUS_ENTRY_CYC = 300,
  parameter int SUS_EXIT_CYC  = 200
) (
  input logic       clk,
  input logic       rst,
  input logic       req_sleep,
  input logic       req_suspend,
  input logic       req_resume,
  input logic       bus_reset,
  input logic [1:0] link_state,
  input logic       busy,
  input logic       clk_stop_req
);

  // length of the current busy run, counted independently of the timer
  int run_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_len <= 0;
    else              run_len <= run_len + 1;
  end

  assert_no_bad_code_R2: assert property (@(posedge clk) disable iff (rst)
    link_state != 2'b11);

  assert_state_moves_at_end_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(link_state) |-> ($fell(busy) || $past(bus_reset)));

  assert_slp_in_len_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_reset) && link_state == 2'b01) |-> run_len == SLP_ENTRY_CYC);

  assert_slp_out_len_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_reset) && link_state == 2'b00 && $past(link_state) == 2'b01)
      |-> run_len == SLP_EXIT_CYC);

  assert_sus_in_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_reset) && link_state == 2'b10) |-> run_len == SUS_ENTRY_CYC);

  assert_sus_out_len_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(bus_reset) && link_state == 2'b00 && $past(link_state) == 2'b10)
      |-> run_len == SUS_EXIT_CYC);

  assert_stop_only_settled_R6: assert property (@(posedge clk) disable iff (rst)
    clk_stop_req |-> (link_state == 2'b10 && !busy));

  assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && link_state == 2'b01 && !req_resume && !bus_reset)
      |=> (link_state == 2'b01 && !busy));

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (link_state == 2'b00 && !busy && !clk_stop_req));

endmodule

bind link_pwr_seq lps_checker #(
  .SLP_ENTRY_CYC (SLP_ENTRY_CYC),
  .SLP_EXIT_CYC  (SLP_EXIT_CYC),
  .SUS_ENTRY_CYC (SUS_ENTRY_CYC),
  .SUS_EXIT_CYC  (SUS_EXIT_CYC)
) i_lps_checker (
  .clk          (clk),
  .rst          (rst),
  .req_sleep    (req_sleep),
  .req_suspend  (req_suspend),
  .req_resume   (req_resume),
  .bus_reset    (bus_reset),
  .link_state   (link_state),
  .busy         (busy),
  .clk_stop_req (clk_stop_req)
);

// File: tb/test_link_pwr_seq.sv
`timescale 1ns/1ps
module test_link_pwr_seq;

  localparam int T_SI = 65;
  localparam int T_SO = 100;
  localparam int T_UI = 300;
  localparam int T_UO = 200;
  localparam int RUN_LIMIT = 2000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_sleep = 1'b0;
  logic       req_suspend = 1'b0;
  logic       req_resume = 1'b0;
  logic       bus_reset = 1'b0;
  logic [1:0] link_state;
  logic       busy;
  logic       clk_stop_req;

  int checks = 0;
  int failures = 0;
  bit stop_seen = 1'b0;

  always #2 clk = ~clk;

  link_pwr_seq #(
    .SLP_ENTRY_CYC (T_SI),
    .SLP_EXIT_CYC  (T_SO),
    .SUS_ENTRY_CYC (T_UI),
    .SUS_EXIT_CYC  (T_UO)
  ) i_link_pwr_seq (
    .clk          (clk),
    .rst          (rst),
    .req_sleep    (req_sleep),
    .req_suspend  (req_suspend),
    .req_resume   (req_resume),
    .bus_reset    (bus_reset),
    .link_state   (link_state),
    .busy         (busy),
    .clk_stop_req (clk_stop_req)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    chk(act == exp, req, what, act, exp);
  endtask

  // drive a one-cycle pulse; returns at the first sample after the edge that took it
  task automatic pulse(input bit s, input bit u, input bit r, input bit b);
    req_sleep = s; req_suspend = u; req_resume = r; bus_reset = b;
    @(negedge clk);
    req_sleep = 0; req_suspend = 0; req_resume = 0; bus_reset = 0;
  endtask

  // counts samples with busy high; records whether clk_stop_req was ever high
  task automatic run_busy(output int n);
    n = 0;
    stop_seen = 1'b0;
    while (busy && n < RUN_LIMIT) begin
      if (clk_stop_req) stop_seen = 1'b1;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R1", "state in reset", link_state, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(link_state == 2'b00 && !busy && !clk_stop_req, "R1", "outputs after reset",
        {link_state, busy, clk_stop_req}, 0);
  endtask

  task automatic t_sleep_cycle();
    int n;
    pulse(1, 0, 0, 0);
    chk_eq("R2", "state kept during sleep entry", link_state, 2'b00);
    run_busy(n);
    chk_eq("R3", "sleep entry length", n, T_SI);
    chk_eq("R3", "state after sleep entry", link_state, 2'b01);
    chk_eq("R6", "clock stop during sleep entry", stop_seen, 0);
    chk_eq("R6", "clock stop in sleep", clk_stop_req, 0);
    pulse(0, 1, 0, 0);
    pulse(1, 0, 0, 0);
    repeat (3) @(negedge clk);
    chk(link_state == 2'b01 && !busy, "R8", "sleep after illegal requests",
        {link_state, busy}, 3'b010);
    pulse(0, 0, 1, 0);
    chk_eq("R2", "state kept during sleep exit", link_state, 2'b01);
    run_busy(n);
    chk_eq("R3", "sleep exit length", n, T_SO);
    chk_eq("R3", "state after sleep exit", link_state, 2'b00);
  endtask

  task automatic t_resume_in_on();
    pulse(0, 0, 1, 0);
    chk(link_state == 2'b00 && !busy, "R8", "resume in on", {link_state, busy}, 0);
  endtask

  task automatic t_suspend_cycle();
    int n;
    pulse(0, 1, 0, 0);
    run_busy(n);
    chk_eq("R4", "suspend entry length", n, T_UI);
    chk_eq("R6", "clock stop during suspend entry", stop_seen, 0);
    chk_eq("R4", "state after suspend entry", link_state, 2'b10);
    chk_eq("R6", "clock stop in settled suspend", clk_stop_req, 1);
    pulse(0, 0, 1, 0);
    chk_eq("R6", "clock stop drops on exit", clk_stop_req, 0);
    repeat (50) @(negedge clk);
    pulse(1, 1, 1, 0);
    run_busy(n);
    chk_eq("R7", "suspend exit length with mid requests", 51 + n, T_UO);
    chk(link_state == 2'b00 && !busy, "R7", "state after suspend exit", {link_state, busy}, 0);
    repeat (2) @(negedge clk);
    chk_eq("R7", "no request replayed", busy, 0);
  endtask

  task automatic t_reset_abort();
    pulse(1, 0, 0, 0);
    repeat (10) @(negedge clk);
    pulse(0, 0, 0, 1);
    chk(link_state == 2'b00 && !busy, "R9", "bus reset aborts sleep entry",
        {link_state, busy}, 0);
    pulse(1, 0, 0, 1);
    chk(link_state == 2'b00 && !busy, "R9", "bus reset beats request",
        {link_state, busy}, 0);
  endtask

  task automatic t_reset_in_suspend();
    int n;
    pulse(0, 1, 0, 0);
    run_busy(n);
    chk_eq("R5", "suspend reached", link_state, 2'b10);
    pulse(0, 0, 0, 1);
    chk(link_state == 2'b00 && !busy && !clk_stop_req, "R5", "bus reset in suspend",
        {link_state, busy, clk_stop_req}, 0);
  endtask

  task automatic t_both_entries();
    int n;
    pulse(1, 1, 0, 0);
    run_busy(n);
    chk(link_state == 2'b10 && n == T_UI, "R10", "suspend wins over sleep",
        n, T_UI);
    pulse(0, 0, 0, 1);
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_up();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_sleep_cycle();
    t_resume_in_on();
    t_suspend_cycle();
    t_reset_abort();
    t_reset_in_suspend();
    t_both_entries();
    finish_up();
  end

endmodule